// File: doc/BRIEF.md
# Port Overvoltage Fault Sequencer

This block is the digital controller behind a pair of connector-protection pass switches: one group on the configuration-channel (CC) lines and one on the sideband-use (SBU) lines. It receives four flags that are already digital but not yet synchronous. They report supply above lockout, CC overvoltage, SBU overvoltage and over-temperature. It drives the enables of both switch groups and the enable of the dead-battery pull-down resistors. It also drives an active-low open-drain fault line, given here as a "pull low" strobe for the pad.

All timing is done with counters on a free-running clock, and every duration is a parameter in clock cycles. Power-up, immediate switch opening on a fault, and a minimum hold-off before reclosing are sequenced here. So are a fast reclose for faults that lasted long, a delayed fault assertion, and a fault release that waits for the switches to close again. A supply loss overrides every other state.

Top module: `port_guard_seq`

## Requirements
- R1: While the synchronized supply flag is low, both switch enables are 0, `db_pulldown_en_o` is 1 and `fault_pull_low_o` is 0 (line released), whatever the fault flags do; this is also the reset state.
- R2: When the synchronized supply flag is seen high in the lockout state, `db_pulldown_en_o` drops at that edge and both switch groups close `PWRUP_CYC` cycles later, provided no fault is seen during the wait.
- R3: Any one of the CC overvoltage, SBU overvoltage or over-temperature flags opens both switch groups at the first clock edge at which the synchronized flag is high, with no counted delay.
- R4: `fault_pull_low_o` goes to 1 exactly `ALARM_CYC` cycles after the switches opened for a fault.
- R5: After a fault opens the switches, they stay open for at least `HOLD_CYC` cycles. They close only once all fault flags are low, and a fault that clears after the hold-off expires closes them one cycle after it is seen clear.
- R6: If a fault flag stays high for more than `LONG_CYC` synchronized cycles, the switches close `FAST_CYC` cycles after the clearing is seen, with no further hold-off.
- R7: `fault_pull_low_o` returns to 0 exactly `RELEASE_CYC` cycles after the switches close following a fault, and not before.
- R8: A low synchronized supply flag opens both switches, re-enables the pull-downs and releases the fault line at the next edge, from any state.
- R9: A fault seen during the hold-off or during the release delay restarts the sequence from the fault state. The hold-off is counted again from that point, and `fault_pull_low_o` stays 1.
- R10: Each input flag passes two synchronizing flops, so a change driven just after a clock edge acts on the state at the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| vsup_ok_i | input | 1 | Supply above lockout (asynchronous) |
| cc_ov_i | input | 1 | CC overvoltage flag (asynchronous) |
| sbu_ov_i | input | 1 | SBU overvoltage flag (asynchronous) |
| hot_i | input | 1 | Over-temperature flag (asynchronous) |
| cc_pass_en_o | output | 1 | Close the CC pass switches |
| sbu_pass_en_o | output | 1 | Close the SBU pass switches |
| db_pulldown_en_o | output | 1 | Enable the dead-battery pull-down resistors |
| fault_pull_low_o | output | 1 | 1 = pull the open-drain fault line low |

## Verification
Two functions can collide in one cycle: the end of the fault-release delay and the arrival of a new fault. A fault can also land on the cycle in which the hold-off would have expired. The bench injects second faults at set offsets inside the hold-off and inside the release window. A per-cycle reference model judges whether the switches reopen, whether the fault line stays asserted, and whether the hold-off restarts from the new entry. Supply loss during an active fault is a further collision, because it must win over the alarm counter in the same edge.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [2:0] {
        ST_DARK,      // supply below lockout
        ST_RAMP,      // power-up delay
        ST_PASS,      // switches closed, no fault
        ST_TRIP,      // fault present, switches open
        ST_COOL,      // fault gone, waiting for reclose
        ST_HANDBACK   // switches closed, fault line still held
    } seq_st_e;

    typedef struct packed {
        logic hot;
        logic sbu_ov;
        logic cc_ov;
        logic supply;
    } flags_t;

    localparam int FLAG_N = $bits(flags_t);

    function automatic int ctr_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic any_fault(input flags_t f);
        return f.cc_ov | f.sbu_ov | f.hot;
    endfunction

    function automatic logic pass_state(input seq_st_e s);
        return (s == ST_PASS) || (s == ST_HANDBACK);
    endfunction

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] safe_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= 1'b0;
                safe_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= d_i[i];
                safe_q[i] <= meta_q[i];
            end
        end
    end

    assign q_o = safe_q;
endmodule

// File: rtl/pgs_seq.sv
module pgs_seq
    import pgs_pkg::*;
#(
    parameter int unsigned PWRUP_CYC   = 875000,
    parameter int unsigned HOLD_CYC    = 7250000,
    parameter int unsigned LONG_CYC    = 10000000,
    parameter int unsigned FAST_CYC    = 125000,
    parameter int unsigned RELEASE_CYC = 1250000
) (
    input  logic    clk,
    input  logic    rst,
    input  flags_t  flg,
    output seq_st_e st,
    output logic    rel_done
);
    localparam int unsigned TMAX = umax(umax(PWRUP_CYC, HOLD_CYC), umax(FAST_CYC, RELEASE_CYC));
    localparam int TW = ctr_w(TMAX);
    localparam int AW = ctr_w(LONG_CYC + 1);

    localparam logic [TW-1:0] T_TOP     = TW'(TMAX);
    localparam logic [TW-1:0] PWR_LAST  = TW'(PWRUP_CYC - 1);
    localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] FAST_LAST = TW'(FAST_CYC - 1);
    localparam logic [TW-1:0] REL_LAST  = TW'(RELEASE_CYC - 1);
    localparam logic [AW-1:0] AGE_TOP   = AW'(LONG_CYC + 1);
    localparam logic [AW-1:0] AGE_LIM   = AW'(LONG_CYC);
    localparam logic [AW-1:0] AGE_ONE   = AW'(1);

    logic [TW-1:0] tmr_q;
    logic [TW-1:0] tmr_inc;
    logic [AW-1:0] age_q;
    logic          long_q;
    logic          flt;
    logic          cool_done;

    assign flt       = any_fault(flg);
    assign tmr_inc   = (tmr_q == T_TOP) ? tmr_q : tmr_q + 1'b1;
    assign cool_done = long_q ? (tmr_q >= FAST_LAST) : (tmr_q >= HOLD_LAST);
    assign rel_done  = flg.supply && (st == ST_HANDBACK) && !flt && (tmr_q == REL_LAST);

    always_ff @(posedge clk) begin
        if (rst || !flg.supply) begin
            st     <= ST_DARK;
            tmr_q  <= '0;
            age_q  <= '0;
            long_q <= 1'b0;
        end else begin
            unique case (st)
                ST_DARK: begin
                    st    <= ST_RAMP;
                    tmr_q <= '0;
                end
                ST_RAMP, ST_PASS, ST_COOL, ST_HANDBACK: begin
                    if (flt) begin
                        st     <= ST_TRIP;
                        tmr_q  <= '0;
                        age_q  <= AGE_ONE;
                        long_q <= 1'b0;
                    end else if (st == ST_RAMP) begin
                        if (tmr_q == PWR_LAST) begin
                            st    <= ST_PASS;
                            tmr_q <= '0;
                        end else begin
                            tmr_q <= tmr_inc;
                        end
                    end else if (st == ST_COOL) begin
                        if (cool_done) begin
                            st    <= ST_HANDBACK;
                            tmr_q <= '0;
                        end else begin
                            tmr_q <= tmr_inc;
                        end
                    end else if (st == ST_HANDBACK) begin
                        if (tmr_q == REL_LAST) begin
                            st    <= ST_PASS;
                            tmr_q <= '0;
                        end else begin
                            tmr_q <= tmr_inc;
                        end
                    end
                end
                ST_TRIP: begin
                    if (flt) begin
                        tmr_q <= tmr_inc;
                        age_q <= (age_q == AGE_TOP) ? age_q : age_q + 1'b1;
                    end else begin
                        st <= ST_COOL;
                        if (age_q > AGE_LIM) begin
                            long_q <= 1'b1;
                            tmr_q  <= '0;
                        end else begin
                            long_q <= 1'b0;
                            tmr_q  <= tmr_inc;
                        end
                    end
                end
                default: st <= ST_DARK;
            endcase
        end
    end
endmodule

// File: rtl/pgs_alarm.sv
module pgs_alarm
    import pgs_pkg::*;
#(
    parameter int unsigned ALARM_CYC = 5000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    supply,
    input  seq_st_e st,
    input  logic    rel_done,
    output logic    pull_low
);
    localparam int CW = ctr_w(ALARM_CYC);
    localparam logic [CW-1:0] A_LAST = CW'(ALARM_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          low_q;
    logic          armed;

    assign armed = (st == ST_TRIP) || (st == ST_COOL);

    always_ff @(posedge clk) begin
        if (rst || !supply || rel_done) begin
            cnt_q <= '0;
            low_q <= 1'b0;
        end else if (armed) begin
            if (!low_q) begin
                if (cnt_q == A_LAST) begin
                    low_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign pull_low = low_q;
endmodule

// File: rtl/port_guard_seq.sv
module port_guard_seq
    import pgs_pkg::*;
#(
    parameter int unsigned PWRUP_CYC   = 875000,
    parameter int unsigned ALARM_CYC   = 5000,
    parameter int unsigned HOLD_CYC    = 7250000,
    parameter int unsigned LONG_CYC    = 10000000,
    parameter int unsigned FAST_CYC    = 125000,
    parameter int unsigned RELEASE_CYC = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic vsup_ok_i,
    input  logic cc_ov_i,
    input  logic sbu_ov_i,
    input  logic hot_i,
    output logic cc_pass_en_o,
    output logic sbu_pass_en_o,
    output logic db_pulldown_en_o,
    output logic fault_pull_low_o
);
    localparam int GROUPS = 2;

    flags_t          flg_raw;
    flags_t          flg_s;
    logic [FLAG_N-1:0] flg_sync;
    seq_st_e         st;
    logic            rel_done;
    logic [GROUPS-1:0] grp_en;

    assign flg_raw = '{hot: hot_i, sbu_ov: sbu_ov_i, cc_ov: cc_ov_i, supply: vsup_ok_i};

    pgs_sync #(.W(FLAG_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (flg_raw),
        .q_o (flg_sync)
    );

    assign flg_s = flags_t'(flg_sync);

    pgs_seq #(
        .PWRUP_CYC  (PWRUP_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .LONG_CYC   (LONG_CYC),
        .FAST_CYC   (FAST_CYC),
        .RELEASE_CYC(RELEASE_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .flg     (flg_s),
        .st      (st),
        .rel_done(rel_done)
    );

    pgs_alarm #(.ALARM_CYC(ALARM_CYC)) u_alarm (
        .clk     (clk),
        .rst     (rst),
        .supply  (flg_s.supply),
        .st      (st),
        .rel_done(rel_done),
        .pull_low(fault_pull_low_o)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_en[g] = pass_state(st);
    end

    assign cc_pass_en_o     = grp_en[0];
    assign sbu_pass_en_o    = grp_en[1];
    assign db_pulldown_en_o = (st == ST_DARK);
endmodule

// File: rtl/pgs_chk.sv
module pgs_chk
    import pgs_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input flags_t flg_s,
    input logic   cc_en,
    input logic   sbu_en,
    input logic   db_en,
    input logic   flt_low
);
    logic fault_s;
    assign fault_s = flg_s.cc_ov | flg_s.sbu_ov | flg_s.hot;

    assert_lockout_safe_R8: assert property (@(posedge clk) disable iff (rst)
        !flg_s.supply |=> (!cc_en && !sbu_en && db_en && !flt_low));

    assert_trip_opens_R3: assert property (@(posedge clk) disable iff (rst)
        (fault_s && (cc_en || sbu_en)) |=> (!cc_en && !sbu_en));

    assert_ramp_leaves_pulldown_R2: assert property (@(posedge clk) disable iff (rst)
        (flg_s.supply && db_en) |=> !db_en);

    assert_alarm_while_open_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flt_low) |-> (!cc_en && !sbu_en));

    assert_release_after_close_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(flt_low) && $past(flg_s.supply)) |-> (cc_en && sbu_en));

    assert_no_close_under_fault_R5: assert property (@(posedge clk) disable iff (rst)
        (fault_s && !cc_en) |=> !cc_en);
endmodule

bind port_guard_seq pgs_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .flg_s  (flg_s),
    .cc_en  (cc_pass_en_o),
    .sbu_en (sbu_pass_en_o),
    .db_en  (db_pulldown_en_o),
    .flt_low(fault_pull_low_o)
);

// File: tb/sim_port_guard_seq.sv
`timescale 1ns/1ps
module sim_port_guard_seq;
    localparam int P = 20;
    localparam int A = 5;
    localparam int H = 60;
    localparam int L = 100;
    localparam int F = 8;
    localparam int R = 15;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, vs, cc, sbu, hot;
    logic cc_en, sbu_en, db_en, flt_low;

    int total = 0;
    int bad = 0;

    port_guard_seq #(
        .PWRUP_CYC(P), .ALARM_CYC(A), .HOLD_CYC(H),
        .LONG_CYC(L), .FAST_CYC(F), .RELEASE_CYC(R)
    ) u0 (
        .clk(clk), .rst(rst), .vsup_ok_i(vs), .cc_ov_i(cc), .sbu_ov_i(sbu), .hot_i(hot),
        .cc_pass_en_o(cc_en), .sbu_pass_en_o(sbu_en),
        .db_pulldown_en_o(db_en), .fault_pull_low_o(flt_low)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // mode: 0 lockout, 1 powering, 2 closed, 3 faulted, 4 waiting, 5 closed+alarm held
    int  m_mode, m_t, m_age, m_acnt;
    bit  m_flo, m_long;
    bit [3:0] m_s1, m_s2;   // {hot, sbu, cc, supply}

    always @(posedge clk) begin
        bit sp, fl, rel;
        if (rst) begin
            m_mode = 0; m_t = 0; m_age = 0; m_acnt = 0; m_flo = 0; m_long = 0;
            m_s1 = '0; m_s2 = '0;
        end else begin
            sp  = m_s2[0];
            fl  = m_s2[1] | m_s2[2] | m_s2[3];
            rel = sp && m_mode == 5 && !fl && m_t == R - 1;
            if (!sp || rel) begin
                m_flo = 0; m_acnt = 0;
            end else if (m_mode == 3 || m_mode == 4) begin
                if (!m_flo) begin
                    if (m_acnt == A - 1) m_flo = 1;
                    else m_acnt++;
                end
            end else m_acnt = 0;

            if (!sp) begin
                m_mode = 0; m_t = 0; m_age = 0; m_long = 0;
            end else if (m_mode == 0) begin
                m_mode = 1; m_t = 0;
            end else if (m_mode == 3) begin
                if (fl) begin m_t++; m_age++; end
                else begin
                    m_mode = 4;
                    m_long = (m_age > L);
                    m_t = m_long ? 0 : m_t + 1;
                end
            end else if (fl) begin
                m_mode = 3; m_t = 0; m_age = 1; m_long = 0;
            end else if (m_mode == 1) begin
                if (m_t == P - 1) begin m_mode = 2; m_t = 0; end else m_t++;
            end else if (m_mode == 4) begin
                if (m_t >= (m_long ? F - 1 : H - 1)) begin m_mode = 5; m_t = 0; end else m_t++;
            end else if (m_mode == 5) begin
                if (m_t == R - 1) begin m_mode = 2; m_t = 0; end else m_t++;
            end
            m_s2 = m_s1;
            m_s1 = {hot, sbu, cc, vs};
        end
    end

    always @(negedge clk) begin
        string tag;
        int    exp_sw;
        case (m_mode)
            0: tag = "R1"; 1: tag = "R2"; 2: tag = "R3";
            3: tag = "R4"; 4: tag = "R5"; default: tag = "R7";
        endcase
        exp_sw = (m_mode == 2 || m_mode == 5) ? 1 : 0;
        chk({tag, " model cc"},  int'(cc_en),   exp_sw);
        chk({tag, " model sbu"}, int'(sbu_en),  exp_sw);
        chk({tag, " model pd"},  int'(db_en),   (m_mode == 0) ? 1 : 0);
        chk({tag, " model flt"}, int'(flt_low), int'(m_flo));
    end

    // ---------------- directed sequences ----------------
    function automatic bit probe(input int which);
        case (which)
            0: return cc_en;
            1: return db_en;
            default: return flt_low;
        endcase
    endfunction

    task automatic wait_for(input int which, input bit val, output int n);
        n = 0;
        while (probe(which) !== val && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n, n2;
        rst = 1; vs = 0; cc = 0; sbu = 0; hot = 0;
        repeat (4) @(negedge clk);
        chk("R1 reset pulldown", int'(db_en), 1);
        chk("R1 reset switch", int'(cc_en | sbu_en), 0);
        chk("R1 reset fault line", int'(flt_low), 0);
        rst = 0;

        // R1: faults ignored while supply low
        cc = 1; hot = 1;
        repeat (10) @(negedge clk);
        chk("R1 lockout fault ignored sw", int'(cc_en), 0);
        chk("R1 lockout fault ignored flt", int'(flt_low), 0);
        chk("R1 lockout pulldown kept", int'(db_en), 1);
        cc = 0; hot = 0;
        repeat (4) @(negedge clk);

        // R2 / R10: power-up
        vs = 1;
        wait_for(1, 1'b0, n);
        chk("R10 supply sync latency", n, 3);
        wait_for(0, 1'b1, n);
        chk("R2 power-up delay", n, P);
        repeat (5) @(negedge clk);

        // R3 / R4 / R5 / R7: short CC fault
        cc = 1;
        wait_for(0, 1'b0, n);
        chk("R3 switches open on CC fault", n, 3);
        chk("R3 sbu group opens too", int'(sbu_en), 0);
        cc = 0;
        wait_for(2, 1'b1, n);
        chk("R4 fault assertion delay", n, A);
        wait_for(0, 1'b1, n2);
        chk("R5 minimum hold-off", n + n2, H);
        wait_for(2, 1'b0, n);
        chk("R7 fault release delay", n, R);
        repeat (5) @(negedge clk);

        // R5: over-temperature held beyond hold-off, short path
        hot = 1;
        wait_for(0, 1'b0, n);
        chk("R3 over-temp opens", n, 3);
        repeat (80) @(negedge clk);
        hot = 0;
        wait_for(0, 1'b1, n);
        chk("R5 close after late clear", n, 4);
        wait_for(2, 1'b0, n);
        chk("R7 release after over-temp", n, R);
        repeat (5) @(negedge clk);

        // R6: long SBU fault
        sbu = 1;
        wait_for(0, 1'b0, n);
        chk("R3 sbu fault opens", n, 3);
        repeat (L + 40) @(negedge clk);
        sbu = 0;
        wait_for(0, 1'b1, n);
        chk("R6 fast reclose after long fault", n, 3 + F);
        wait_for(2, 1'b0, n);
        chk("R7 release after long fault", n, R);
        repeat (5) @(negedge clk);

        // R9: new fault during release window
        cc = 1;
        wait_for(0, 1'b0, n);
        cc = 0;
        wait_for(0, 1'b1, n);
        repeat (3) @(negedge clk);
        sbu = 1;
        wait_for(0, 1'b0, n);
        chk("R9 refault in release opens", n, 3);
        chk("R9 fault line kept low", int'(flt_low), 1);
        sbu = 0;
        wait_for(0, 1'b1, n);
        chk("R9 hold-off restarted", n, H);
        chk("R9 fault line still low at reclose", int'(flt_low), 1);
        wait_for(2, 1'b0, n);
        chk("R7 release after restart", n, R);
        repeat (5) @(negedge clk);

        // R9: new fault during hold-off
        cc = 1;
        wait_for(0, 1'b0, n);
        cc = 0;
        repeat (20) @(negedge clk);
        hot = 1;
        @(negedge clk);
        hot = 0;
        wait_for(0, 1'b1, n);
        chk("R9 hold-off restarted in wait", n, 2 + H);
        chk("R9 fault line low through restart", int'(flt_low), 1);
        wait_for(2, 1'b0, n);
        chk("R7 release after wait restart", n, R);
        repeat (5) @(negedge clk);

        // R8: supply loss during active fault
        cc = 1;
        wait_for(2, 1'b1, n);
        vs = 0;
        wait_for(1, 1'b1, n);
        chk("R8 pulldown back on supply loss", n, 3);
        chk("R8 fault line released", int'(flt_low), 0);
        chk("R8 switches open", int'(cc_en | sbu_en), 0);
        cc = 0;
        repeat (4) @(negedge clk);
        vs = 1;
        wait_for(1, 1'b0, n);
        wait_for(0, 1'b1, n);
        chk("R2 power-up after supply return", n, P);
        repeat (10) @(negedge clk);

        finish_run();
    end
endmodule